// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits on the byte-write path in front of a paged non-volatile array. It sees each completed write cycle as an address and a data byte. It recognises two command sequences in that stream. A three-byte prefix turns protection on and also opens the one window in which a protected block accepts data. A six-byte sequence turns protection off. Each block of the address space (an in-block address of `IN_W` bits, with the block index above it) has its own protect flag. The flag survives the soft reset and starts cleared at power-up, so it stands in for non-volatile storage.

Every accepted write opens a page-load window. Each further write to the same block restarts that window. When the window runs out, or the page limit is reached, the emulated programming period (busy) starts. Any change of a protect flag takes effect at the end of that period. A write that is refused because its block is protected still starts a full busy period, but it stores nothing. Command bytes are never passed to the array.

Top module: `wp_guard`

## Requirements
- R1: After `rst`, the outputs `wr_allow`, `busy_start` and `busy` are 0. At power-up every bit of `prot_flags` is 0.
- R2: A write to an unprotected block that is not a command byte produces a one-cycle `wr_allow` pulse in the cycle after the sampling clock edge.
- R3: Each write accepted in the load phase restarts a window of `WIN_CYC` cycles. `busy_start` pulses `WIN_CYC` cycles after the last accepted write. `busy` then stays high for exactly `BUSY_CYC` cycles.
- R4: When the `LOAD_MAX`-th byte of one load phase is accepted, busy starts at once: `busy_start` is high in the same cycle as that byte's `wr_allow`.
- R5: The sequence AA@0x05555, 55@0x02AAA, A0@0x05555 (in-block address, data byte) sets the block's flag at the end of the following busy period, even if no data byte follows. None of the command bytes produces `wr_allow`.
- R6: A write to a protected block without the prefix gets no `wr_allow`. It raises `busy_start` in the cycle after its clock edge and holds `busy` for `BUSY_CYC` cycles. The flags do not change.
- R7: On a protected block, data bytes written after the three-byte prefix produce `wr_allow`, and the flag stays set.
- R8: The sequence AA@0x05555, 55@0x02AAA, 80@0x05555, AA@0x05555, 55@0x02AAA, 20@0x05555 clears the block's flag at the end of the following busy period.
- R9: The flags are independent per block, and at most one flag changes in any cycle. All bytes of one sequence must target the same block.
- R10: A write that does not match the next expected sequence byte ends the sequence. It is then judged as if no sequence had started.
- R11: A strobe with `oe_act` high is ignored completely: no `wr_allow`, no busy, and an unfinished sequence keeps its progress.
- R12: While `busy` is high, writes are ignored: no `wr_allow`, and the busy period is not extended.
- R13: During a load phase, a write to a different block is dropped and does not restart the window.
- R14: `rst` leaves `prot_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset (flags kept) |
| wr_stb | input | 1 | One-cycle strobe: a byte write cycle completed |
| oe_act | input | 1 | Output enable asserted; inhibits the write |
| wr_addr | input | IN_W+log2(NBLK) | Block index above the in-block address |
| wr_data | input | 8 | Written byte |
| wr_allow | output | 1 | Registered pulse: pass this byte to the array |
| busy_start | output | 1 | Registered pulse: programming period begins |
| busy | output | 1 | Programming period in progress |
| prot_flags | output | NBLK | Current protect flag per block |

## Verification
The assertions check on every cycle the properties that hold regardless of the sequence history. `wr_allow` only follows an uninhibited strobe and never one taken while busy. Every rise of `busy` is marked by `busy_start`. Flags move only as busy ends, and only one flag moves at a time. The sequence decoding itself needs the bench's scenarios to be shown: command recognition, mismatch fallback, inhibit without loss of progress, exact window and busy lengths, the page limit, and flag persistence across the soft reset.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PFX1,
    ST_PFX2,
    ST_OFF3,
    ST_OFF4,
    ST_OFF5,
    ST_LOAD,
    ST_BUSY
  } wp_state_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SET,
    ACT_CLR
  } wp_act_e;

  // Decoded command byte matches of one write cycle
  typedef struct packed {
    logic aa_hi;
    logic h55_lo;
    logic a0_hi;
    logic h80_hi;
    logic h20_hi;
  } wp_hit_t;

  localparam logic [16:0] CMD_ADR_HI = 17'h05555;
  localparam logic [16:0] CMD_ADR_LO = 17'h02AAA;
  localparam logic [7:0]  CMD_B_AA   = 8'hAA;
  localparam logic [7:0]  CMD_B_55   = 8'h55;
  localparam logic [7:0]  CMD_B_A0   = 8'hA0;
  localparam logic [7:0]  CMD_B_80   = 8'h80;
  localparam logic [7:0]  CMD_B_20   = 8'h20;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter int IN_W = 17
) (
  input  logic [IN_W-1:0] in_addr,
  input  logic [7:0]      data,
  output wp_hit_t         hit
);

  logic at_hi, at_lo;

  always_comb begin
    at_hi = (in_addr == IN_W'(CMD_ADR_HI));
    at_lo = (in_addr == IN_W'(CMD_ADR_LO));
    hit.aa_hi  = at_hi && (data == CMD_B_AA);
    hit.h55_lo = at_lo && (data == CMD_B_55);
    hit.a0_hi  = at_hi && (data == CMD_B_A0);
    hit.h80_hi = at_hi && (data == CMD_B_80);
    hit.h20_hi = at_hi && (data == CMD_B_20);
  end

endmodule

// File: rtl/wp_timer.sv
module wp_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/wp_flag_bank.sv
module wp_flag_bank #(
  parameter int NBLK = 4,
  parameter int BW   = 2
) (
  input  logic            clk,
  input  logic            upd,
  input  logic [BW-1:0]   upd_blk,
  input  logic            upd_val,
  output logic [NBLK-1:0] flags
);

  // Power-up value only; no reset input: models non-volatile cells
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic f_q = 1'b0;
    always_ff @(posedge clk) begin
      if (upd && (upd_blk == BW'(i))) f_q <= upd_val;
    end
    assign flags[i] = f_q;
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int IN_W     = 17,
  parameter int WIN_CYC  = 15000,
  parameter int BUSY_CYC = 1000000,
  parameter int LOAD_MAX = 128,
  localparam int BW      = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ADDR_W  = IN_W + BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              oe_act,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_allow,
  output logic              busy_start,
  output logic              busy,
  output logic [NBLK-1:0]   prot_flags
);

  localparam int TMAX = (WIN_CYC > BUSY_CYC) ? WIN_CYC : BUSY_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(LOAD_MAX + 1);

  wp_state_e st_q, st_n;
  wp_act_e   act_q, act_n;
  logic [BW-1:0] blk_q, blk_n, blk;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [IN_W-1:0] ia;
  logic w, same, ord;
  logic allow_n, bstart_n;
  logic t_load, t_zero;
  logic [CW-1:0] t_val;
  logic upd;
  wp_hit_t hit;

  assign w    = wr_stb && !oe_act;
  assign blk  = wr_addr[ADDR_W-1:IN_W];
  assign ia   = wr_addr[IN_W-1:0];
  assign same = (blk == blk_q);

  wp_cmd_decode #(.IN_W(IN_W)) u_dec (
    .in_addr (ia),
    .data    (wr_data),
    .hit     (hit)
  );

  wp_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  wp_flag_bank #(.NBLK(NBLK), .BW(BW)) u_flags (
    .clk     (clk),
    .upd     (upd && !rst),
    .upd_blk (blk_q),
    .upd_val (act_q == ACT_SET),
    .flags   (prot_flags)
  );

  always_comb begin
    st_n     = st_q;
    act_n    = act_q;
    blk_n    = blk_q;
    cnt_n    = cnt_q;
    allow_n  = 1'b0;
    bstart_n = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    upd      = 1'b0;
    ord      = 1'b0;

    unique case (st_q)
      ST_IDLE: if (w) ord = 1'b1;
      ST_PFX1: if (w) begin
        if (same && hit.h55_lo) st_n = ST_PFX2;
        else                    ord  = 1'b1;
      end
      ST_PFX2: if (w) begin
        if (same && hit.a0_hi) begin
          st_n   = ST_LOAD;
          act_n  = ACT_SET;
          cnt_n  = '0;
          t_load = 1'b1;
          t_val  = CW'(WIN_CYC - 1);
        end else if (same && hit.h80_hi) begin
          st_n = ST_OFF3;
        end else begin
          ord = 1'b1;
        end
      end
      ST_OFF3: if (w) begin
        if (same && hit.aa_hi) st_n = ST_OFF4;
        else                   ord  = 1'b1;
      end
      ST_OFF4: if (w) begin
        if (same && hit.h55_lo) st_n = ST_OFF5;
        else                    ord  = 1'b1;
      end
      ST_OFF5: if (w) begin
        if (same && hit.h20_hi) begin
          st_n   = ST_LOAD;
          act_n  = ACT_CLR;
          cnt_n  = '0;
          t_load = 1'b1;
          t_val  = CW'(WIN_CYC - 1);
        end else begin
          ord = 1'b1;
        end
      end
      ST_LOAD: begin
        if (w && same) begin
          allow_n = 1'b1;
          cnt_n   = cnt_q + 1'b1;
          t_load  = 1'b1;
          if (cnt_q + 1'b1 == LW'(LOAD_MAX)) begin
            st_n     = ST_BUSY;
            bstart_n = 1'b1;
            t_val    = CW'(BUSY_CYC - 1);
          end else begin
            t_val = CW'(WIN_CYC - 1);
          end
        end else if (t_zero) begin
          st_n     = ST_BUSY;
          bstart_n = 1'b1;
          t_load   = 1'b1;
          t_val    = CW'(BUSY_CYC - 1);
        end
      end
      ST_BUSY: if (t_zero) begin
        st_n  = ST_IDLE;
        upd   = (act_q != ACT_NONE);
        act_n = ACT_NONE;
      end
      default: st_n = ST_IDLE;
    endcase

    // Idle judgement, also used when a sequence is broken
    if (ord) begin
      blk_n = blk;
      act_n = ACT_NONE;
      if (hit.aa_hi) begin
        st_n = ST_PFX1;
      end else if (prot_flags[blk]) begin
        st_n     = ST_BUSY;
        bstart_n = 1'b1;
        t_load   = 1'b1;
        t_val    = CW'(BUSY_CYC - 1);
      end else begin
        allow_n = 1'b1;
        cnt_n   = LW'(1);
        t_load  = 1'b1;
        if (LOAD_MAX == 1) begin
          st_n     = ST_BUSY;
          bstart_n = 1'b1;
          t_val    = CW'(BUSY_CYC - 1);
        end else begin
          st_n  = ST_LOAD;
          t_val = CW'(WIN_CYC - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      act_q      <= ACT_NONE;
      blk_q      <= '0;
      cnt_q      <= '0;
      wr_allow   <= 1'b0;
      busy_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      st_q       <= st_n;
      act_q      <= act_n;
      blk_q      <= blk_n;
      cnt_q      <= cnt_n;
      wr_allow   <= allow_n;
      busy_start <= bstart_n;
      busy       <= (st_n == ST_BUSY);
    end
  end

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int NBLK = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_stb,
  input logic            oe_act,
  input logic            wr_allow,
  input logic            busy_start,
  input logic            busy,
  input logic [NBLK-1:0] prot_flags
);

  assert_allow_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_allow |-> $past(wr_stb && !oe_act));

  assert_oe_inhibit_R11: assert property (@(posedge clk) disable iff (rst)
    $past(wr_stb && oe_act) |-> !wr_allow);

  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !wr_allow);

  assert_start_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy_start |-> busy);

  assert_busy_rise_marked_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> busy_start);

  assert_flag_only_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(prot_flags));

  assert_one_block_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(prot_flags ^ $past(prot_flags)) <= 1);

endmodule

bind wp_guard wp_guard_chk #(.NBLK(NBLK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .oe_act     (oe_act),
  .wr_allow   (wr_allow),
  .busy_start (busy_start),
  .busy       (busy),
  .prot_flags (prot_flags)
);

// File: tb/wp_guard_tb.sv
module wp_guard_tb;

  localparam int NB   = 2;
  localparam int IW   = 17;
  localparam int WIN  = 4;
  localparam int BSY  = 6;
  localparam int LMAX = 4;
  localparam int AW   = IW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic oe_act = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_allow, busy_start, busy;
  logic [NB-1:0] prot_flags;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wp_guard #(.NBLK(NB), .IN_W(IW), .WIN_CYC(WIN), .BUSY_CYC(BSY),
             .LOAD_MAX(LMAX)) u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .oe_act(oe_act),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_allow(wr_allow),
    .busy_start(busy_start), .busy(busy), .prot_flags(prot_flags)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge
  task automatic do_wr(input logic b, input logic [16:0] a, input logic [7:0] d,
                       input logic inh, output logic al, output logic bs);
    wr_addr = {b, a};
    wr_data = d;
    wr_stb  = 1'b1;
    oe_act  = inh;
    @(negedge clk);
    al = wr_allow;
    bs = busy_start;
    wr_stb = 1'b0;
    oe_act = 1'b0;
  endtask

  task automatic wr_exp(input string tag, input logic b, input logic [16:0] a,
                        input logic [7:0] d, input int exp_al, input int exp_bs);
    logic al, bs;
    do_wr(b, a, d, 1'b0, al, bs);
    check({tag, " allow"}, int'(al), exp_al);
    check({tag, " start"}, int'(bs), exp_bs);
  endtask

  task automatic wait_start(input string tag, input int exp);
    int j = 0;
    while (!busy_start && j < 100) begin
      @(negedge clk);
      j++;
    end
    check({tag, " start delay"}, j, exp);
  endtask

  task automatic count_busy(input string tag, input int exp);
    int n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check({tag, " busy length"}, n, exp);
  endtask

  task automatic seq_on(input string tag, input logic b);
    wr_exp(tag, b, 17'h05555, 8'hAA, 0, 0);
    wr_exp(tag, b, 17'h02AAA, 8'h55, 0, 0);
    wr_exp(tag, b, 17'h05555, 8'hA0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic al, bs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 flags", int'(prot_flags), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 allow", int'(wr_allow), 0);

    // R2/R3 single unprotected write
    wr_exp("R2 plain", 1'b0, 17'h00010, 8'h12, 1, 0);
    wait_start("R3 single", WIN);
    count_busy("R3 single", BSY);

    // R3 page: window restarts on each write
    wr_exp("R3 page", 1'b0, 17'h00020, 8'h01, 1, 0);
    repeat (2) @(negedge clk);
    wr_exp("R3 page", 1'b0, 17'h00021, 8'h02, 1, 0);
    repeat (3) @(negedge clk);
    wr_exp("R3 page", 1'b0, 17'h00022, 8'h03, 1, 0);
    wait_start("R3 page", WIN);
    count_busy("R3 page", BSY);

    // R4 page limit
    for (int i = 0; i < LMAX; i++)
      wr_exp("R4 limit", 1'b0, 17'(32'h40 + i), 8'(i), 1, (i == LMAX - 1) ? 1 : 0);
    count_busy("R4 limit", BSY);

    // R5 enable on block 1 with no data bytes
    seq_on("R5 enable", 1'b1);
    wait_start("R5 enable", WIN);
    count_busy("R5 enable", BSY);
    check("R5 flags", int'(prot_flags), 2);

    // R6 blocked write
    wr_exp("R6 blocked", 1'b1, 17'h00100, 8'h5A, 0, 1);
    count_busy("R6 blocked", BSY);
    check("R6 flags", int'(prot_flags), 2);

    // R9 other block still open
    wr_exp("R9 block0", 1'b0, 17'h00100, 8'h5A, 1, 0);
    wait_start("R9 block0", WIN);
    count_busy("R9 block0", BSY);

    // R7 prefix then data on protected block
    seq_on("R7 prefix", 1'b1);
    wr_exp("R7 data", 1'b1, 17'h00200, 8'hC3, 1, 0);
    wr_exp("R7 data", 1'b1, 17'h00201, 8'h3C, 1, 0);
    wait_start("R7 data", WIN);
    count_busy("R7 data", BSY);
    check("R7 flags", int'(prot_flags), 2);

    // R14 soft reset keeps flags
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R14 flags", int'(prot_flags), 2);
    check("R14 busy", int'(busy), 0);

    // R10 broken sequence judged as ordinary write
    wr_exp("R10 prot", 1'b1, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R10 prot", 1'b1, 17'h02AAA, 8'h55, 0, 0);
    wr_exp("R10 prot", 1'b1, 17'h00100, 8'h33, 0, 1);
    count_busy("R10 prot", BSY);
    wr_exp("R10 open", 1'b0, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R10 open", 1'b0, 17'h00200, 8'h77, 1, 0);
    wait_start("R10 open", WIN);
    count_busy("R10 open", BSY);

    // R9 sequence split across blocks is a mismatch
    wr_exp("R9 split", 1'b0, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R9 split", 1'b1, 17'h02AAA, 8'h55, 0, 1);
    count_busy("R9 split", BSY);

    // R11 inhibited strobe keeps sequence progress
    wr_exp("R11 seq", 1'b1, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R11 seq", 1'b1, 17'h02AAA, 8'h55, 0, 0);
    do_wr(1'b1, 17'h00000, 8'h99, 1'b1, al, bs);
    check("R11 inh allow", int'(al), 0);
    check("R11 inh start", int'(bs), 0);
    wr_exp("R11 seq", 1'b1, 17'h05555, 8'hA0, 0, 0);
    wr_exp("R11 data", 1'b1, 17'h00300, 8'h11, 1, 0);
    wait_start("R11 data", WIN);
    count_busy("R11 data", BSY);

    // R8 disable sequence
    wr_exp("R8 off", 1'b1, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R8 off", 1'b1, 17'h02AAA, 8'h55, 0, 0);
    wr_exp("R8 off", 1'b1, 17'h05555, 8'h80, 0, 0);
    wr_exp("R8 off", 1'b1, 17'h05555, 8'hAA, 0, 0);
    wr_exp("R8 off", 1'b1, 17'h02AAA, 8'h55, 0, 0);
    wr_exp("R8 off", 1'b1, 17'h05555, 8'h20, 0, 0);
    wait_start("R8 off", WIN);
    count_busy("R8 off", BSY);
    check("R8 flags", int'(prot_flags), 0);

    // R11 inhibited strobe on open block does nothing
    do_wr(1'b0, 17'h00400, 8'h44, 1'b1, al, bs);
    check("R11 idle allow", int'(al), 0);
    repeat (WIN + 1) @(negedge clk);
    check("R11 idle busy", int'(busy), 0);

    // R13 other-block write in load phase dropped
    wr_exp("R13 first", 1'b0, 17'h00500, 8'h01, 1, 0);
    wr_exp("R13 other", 1'b1, 17'h00500, 8'h02, 0, 0);
    wait_start("R13", WIN - 1);
    count_busy("R13", BSY);

    // R12 write during busy ignored
    wr_exp("R12 first", 1'b0, 17'h00600, 8'h01, 1, 0);
    wait_start("R12", WIN);
    wr_exp("R12 during", 1'b0, 17'h00601, 8'h02, 0, 0);
    count_busy("R12", BSY - 1);
    repeat (WIN + 1) @(negedge clk);
    check("R12 no restart", int'(busy), 0);
    check("R12 flags", int'(prot_flags), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule